// File: doc/BRIEF.md
# Borrow-Save Signed-Digit Adder

This block adds two radix-2 signed-digit numbers. Each digit is held as a pair of bits: a positive bit and a negative bit. The digit's value is the positive bit minus the negative bit. Because the representation is redundant, the sum is formed without any carry or borrow running along the word. Two rows of three-input cells each resolve a digit locally. Every output digit depends only on input digits in a window of three positions at or below it, so the depth is two cells for any width.

The block is purely combinational. Operands have `DIGITS` digit positions and the result has `DIGITS+1`. The result is left in borrow-save form, and no step reduces it to a unique representation. A consumer that needs an ordinary two's-complement value subtracts the negative vector from the positive vector.

Top module: `bsd_adder`

## Requirements
- R1: A digit at position i with positive bit p and negative bit n is worth (p − n)·2^i. The coding (1,1) is legal and is worth zero, the same as (0,0).
- R2: For every operand pair, the value of the result vectors equals the sum of the operand values.
- R3: The result has DIGITS+1 positions, and bit 0 of `sum_neg` is always 0.
- R4: A change in the operand digits at position k leaves every result digit below position k unchanged. It also leaves every result digit above position k+2 unchanged.
- R5: When all operand bits are zero, all result bits are zero.
- R6: The result value always lies within ±(2^(DIGITS+1) − 2). This extreme is reached when both operands have every digit at +1, or both have every digit at −1.
- R7: Adding an operand to its own negation gives a result worth zero. The negation is formed by swapping the operand's positive and negative vectors.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| x_pos | input | DIGITS | Positive bits of operand X |
| x_neg | input | DIGITS | Negative bits of operand X |
| y_pos | input | DIGITS | Positive bits of operand Y |
| y_neg | input | DIGITS | Negative bits of operand Y |
| sum_pos | output | DIGITS+1 | Positive bits of the result |
| sum_neg | output | DIGITS+1 | Negative bits of the result |

## Verification
The assertions are evaluated whenever the inputs settle, and they assume every operand bit is a known 0 or 1. Checks are skipped while any input is unknown. They also assume the widths stay small enough that the values fit a 64-bit signed integer. The bench drives only fully defined vectors, from constant patterns or from random words, and it changes them once per clock so that the block settles well before the outputs are sampled.

// File: rtl/bsd_adder.sv
module bsd_adder #(
  parameter int DIGITS = 16
) (
  input  logic [DIGITS-1:0] x_pos,
  input  logic [DIGITS-1:0] x_neg,
  input  logic [DIGITS-1:0] y_pos,
  input  logic [DIGITS-1:0] y_neg,
  output logic [DIGITS:0]   sum_pos,
  output logic [DIGITS:0]   sum_neg
);
  localparam int W = DIGITS + 1;

  // cell: 2*hi - lo = a + b - d ; returns {hi, lo}
  function automatic logic [1:0] ppm(input logic a, input logic b, input logic d);
    ppm = {(a & b) | (a & ~d) | (b & ~d), a ^ b ^ d};
  endfunction

  logic [W-1:0] xp_e, xn_e, yp_e, yn_e;
  logic [W-1:0] mid_pos, mid_neg;

  assign xp_e = {1'b0, x_pos};
  assign xn_e = {1'b0, x_neg};
  assign yp_e = {1'b0, y_pos};
  assign yn_e = {1'b0, y_neg};

  assign mid_pos[0] = 1'b0;
  assign sum_neg[0] = 1'b0;

  for (genvar i = 0; i < W; i++) begin : g_digit
    logic [1:0] r1, r2;
    assign r1 = ppm(xp_e[i], yp_e[i], xn_e[i]);
    assign mid_neg[i] = r1[0];
    assign r2 = ppm(mid_neg[i], yn_e[i], mid_pos[i]);
    assign sum_pos[i] = r2[0];
    if (i < W - 1) begin : g_up
      assign mid_pos[i+1] = r1[1];
      assign sum_neg[i+1] = r2[1];
    end
  end
endmodule

// File: rtl/bsd_adder_chk.sv
module bsd_adder_chk #(
  parameter int DIGITS = 16
) (
  input logic [DIGITS-1:0] x_pos,
  input logic [DIGITS-1:0] x_neg,
  input logic [DIGITS-1:0] y_pos,
  input logic [DIGITS-1:0] y_neg,
  input logic [DIGITS:0]   sum_pos,
  input logic [DIGITS:0]   sum_neg
);
  localparam longint LIMIT = (64'sd1 <<< (DIGITS + 1)) - 2;

  function automatic longint val(input logic [63:0] p, input logic [63:0] n);
    longint acc = 0;
    for (int i = 0; i < 64; i++)
      acc += (longint'(p[i]) - longint'(n[i])) <<< i;
    return acc;
  endfunction

  longint vx, vy, vs;
  logic known;

  always_comb begin
    known = !$isunknown({x_pos, x_neg, y_pos, y_neg, sum_pos, sum_neg});
    vx = val(64'(x_pos), 64'(x_neg));
    vy = val(64'(y_pos), 64'(y_neg));
    vs = val(64'(sum_pos), 64'(sum_neg));
    if (known) begin
      assert_sum_value_R2: assert (vs == vx + vy);
      assert_low_neg_clear_R3: assert (sum_neg[0] == 1'b0);
      assert_result_range_R6: assert (vs <= LIMIT && vs >= -LIMIT);
      if ({x_pos, x_neg, y_pos, y_neg} == '0)
        assert_zero_in_zero_out_R5: assert (sum_pos == '0 && sum_neg == '0);
      if (y_pos == x_neg && y_neg == x_pos)
        assert_negation_zero_R7: assert (vs == 0);
    end
  end
endmodule

bind bsd_adder bsd_adder_chk #(.DIGITS(DIGITS)) u_chk (.*);

// File: tb/test_bsd_adder.sv
module test_bsd_adder;
  localparam int N = 16;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [N-1:0] x_pos, x_neg, y_pos, y_neg;
  logic [N:0] sum_pos, sum_neg;
  int tests = 0, fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  bsd_adder #(.DIGITS(N)) i_bsd_adder (.*);

  function automatic int val(input logic [N:0] p, input logic [N:0] n);
    int acc = 0;
    for (int i = 0; i <= N; i++) acc += (int'(p[i]) - int'(n[i])) * (1 << i);
    return acc;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic drive(input logic [N-1:0] xp, xn, yp, yn);
    @(posedge clk);
    x_pos = xp; x_neg = xn; y_pos = yp; y_neg = yn;
    @(negedge clk);
  endtask

  function automatic int expect_sum();
    return val({1'b0, x_pos}, {1'b0, x_neg}) + val({1'b0, y_pos}, {1'b0, y_neg});
  endfunction

  task automatic check_sum(input string req);
    chk(req, val(sum_pos, sum_neg), expect_sum());
    chk("R3", int'(sum_neg[0]), 0);
  endtask

  initial begin
    #2000000;
    fails++; tests++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [N:0] bp, bn;
    x_pos = '0; x_neg = '0; y_pos = '0; y_neg = '0;
    repeat (3) @(posedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R5: zero operands give an all-zero result
    chk("R5", int'(sum_pos), 0);
    chk("R5", int'(sum_neg), 0);

    // R1: every digit coded (1,1) is worth zero
    drive('1, '1, '0, '0);
    chk("R1", val(sum_pos, sum_neg), 0);
    drive(16'h0005, 16'h0005, 16'h0003, 16'h0000);
    chk("R1", val(sum_pos, sum_neg), 3);

    // R6: extremes
    drive('1, '0, '1, '0);
    chk("R6", val(sum_pos, sum_neg), (1 << (N + 1)) - 2);
    drive('0, '1, '0, '1);
    chk("R6", val(sum_pos, sum_neg), -((1 << (N + 1)) - 2));
    drive('1, '0, '0, '1);
    check_sum("R2");

    // R2: random operands
    for (int t = 0; t < 300; t++) begin
      drive(N'($urandom), N'($urandom), N'($urandom), N'($urandom));
      check_sum("R2");
    end

    // R7: operand plus its negation
    for (int t = 0; t < 20; t++) begin
      logic [N-1:0] a, b;
      a = N'($urandom); b = N'($urandom);
      drive(a, b, b, a);
      chk("R7", val(sum_pos, sum_neg), 0);
    end

    // R4: locality of a digit change at position k
    for (int t = 0; t < 40; t++) begin
      logic [N-1:0] a, b, c, d;
      int k;
      a = N'($urandom); b = N'($urandom); c = N'($urandom); d = N'($urandom);
      k = t % N;
      drive(a, b, c, d);
      bp = sum_pos; bn = sum_neg;
      drive(a ^ (N'(1) << k), b ^ (N'($urandom & 1) << k), c, d ^ (N'(1) << k));
      for (int i = 0; i <= N; i++)
        if (i < k || i > k + 2) begin
          chk("R4", int'(sum_pos[i]), int'(bp[i]));
          chk("R4", int'(sum_neg[i]), int'(bn[i]));
        end
      check_sum("R2");
    end

    drive('0, '0, '0, '0);
    chk("R5", int'(sum_pos) | int'(sum_neg), 0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule